// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit forms the memory address for a single load or store in a 32-bit datapath. It receives the already-decoded parts of the instruction: the base register value, the address of the instruction itself, an immediate or register offset, the offset's sign, a shift applied to register offsets, the indexing mode and the transfer size. One cycle later it presents the effective address, the value to write back into the base register, the enable for that writeback, and an alignment fault flag.

A second function formats load data. The raw memory word for the request in flight is fed back in the response cycle. The unit returns either that word unchanged, or a single byte in the low eight bits with the rest cleared. The byte lane is chosen by the low address bits and an endianness input that is captured with the request.

Reading the register file, the bus protocol and instruction decode are handled by neighbouring blocks.

Top module: `ea_unit`

## Requirements
- R1: Mode code 0 (pre-indexed) gives an effective address of base plus or minus the offset, and `wb_en` stays 0.
- R2: Mode code 1 (pre-indexed with writeback) gives an effective address of base plus or minus the offset. That same value appears on `wb_value`, and `wb_en` is 1.
- R3: Mode code 2 (post-indexed) gives an effective address equal to the unmodified base. `wb_value` carries base plus or minus the offset, and `wb_en` is 1.
- R4: When `off_is_reg` is 1, the offset is `off_reg`. When it is 0, the offset is the 12-bit `off_imm` zero-extended. When `off_neg` is 1, the offset is subtracted instead of added. The sum wraps modulo 2^32.
- R5: A register offset is shifted logically by `shift_amt` (0 means no shift) before use. A `shift_dir` of 0 shifts left and 1 shifts right. An immediate offset is never shifted.
- R6: When `pc_rel` is 1, the base is `inst_addr` + 8 and the immediate offset is used. In this case `base_val`, `off_reg`, `off_is_reg`, the shift controls and the mode code have no effect, and `wb_en` is 0.
- R7: A word access (`size_word` = 1) whose effective address has a nonzero bits [1:0] raises `align_fault` and forces `wb_en` to 0. A byte access never faults.
- R8: For a byte access, `load_result[7:0]` is byte k = eff_addr[1:0] of `load_word`, taken from bits [8k+7:8k] when `big_endian` is 0 and from byte 3-k when it is 1. `load_result[31:8]` is 0. For a word access, `load_result` equals `load_word`.
- R9: Results appear on the clock edge after a cycle with `req_valid` high, marked by `rsp_valid`. `wb_en` and `align_fault` are 0 in any cycle where `rsp_valid` is 0. After reset, every output register reads 0.
- R10: Mode code 3 behaves exactly as mode code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| base_val | input | 32 | Base register contents |
| inst_addr | input | 32 | Address of the load/store instruction |
| pc_rel | input | 1 | Use the instruction address + 8 as the base |
| idx_mode | input | 2 | 0 pre, 1 pre with writeback, 2 post, 3 as 0 |
| off_is_reg | input | 1 | Offset comes from off_reg |
| off_imm | input | 12 | Immediate offset magnitude |
| off_reg | input | 32 | Register offset magnitude |
| off_neg | input | 1 | Subtract the offset |
| shift_dir | input | 1 | 0 logical left, 1 logical right |
| shift_amt | input | 5 | Register offset shift amount |
| size_word | input | 1 | 1 word transfer, 0 byte transfer |
| big_endian | input | 1 | Byte numbering for byte loads |
| load_word | input | 32 | Raw memory word in the response cycle |
| rsp_valid | output | 1 | Outputs below belong to a request |
| eff_addr | output | 32 | Effective address |
| wb_value | output | 32 | Base plus or minus offset |
| wb_en | output | 1 | Write wb_value into the base register |
| align_fault | output | 1 | Misaligned word access |
| load_result | output | 32 | Formatted load data |

## Verification
The alignment check and the base writeback are evaluated in the same cycle, and a fault must cancel a writeback that the mode would otherwise request. The sweep provokes this by pairing bases with low bits 1 to 3 and small shifted or immediate offsets with every mode and both sizes. In post-indexed mode the fault is therefore judged on the unmodified base, not on the written-back sum. The bench computes the fault and the gated enable arithmetically from the mode, size and address, and compares both with the outputs in the response cycle. The byte formatter is checked in that same response cycle against a word whose four lanes are all distinct.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    IDX_PRE    = 2'd0,
    IDX_PRE_WB = 2'd1,
    IDX_POST   = 2'd2,
    IDX_RSVD   = 2'd3
  } idx_mode_e;

  typedef enum logic {
    SH_LEFT  = 1'b0,
    SH_RIGHT = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/ea_offset_gen.sv
module ea_offset_gen #(
  parameter int W     = 32,
  parameter int IMM_W = 12,
  parameter int SH_W  = 5
) (
  input  logic [W-1:0]     reg_off,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_reg,
  input  ea_pkg::shift_dir_e dir,
  input  logic [SH_W-1:0]  amt,
  output logic [W-1:0]     magnitude
);
  // logarithmic shifter: stage i moves by 2**i when amt[i] is set
  logic [W-1:0] stage [SH_W+1];

  assign stage[0] = reg_off;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    always_comb begin
      if (!amt[i]) begin
        stage[i+1] = stage[i];
      end else if (dir == ea_pkg::SH_LEFT) begin
        stage[i+1] = stage[i] << (2**i);
      end else begin
        stage[i+1] = stage[i] >> (2**i);
      end
    end
  end

  always_comb begin
    if (use_reg) begin
      magnitude = stage[SH_W];
    end else begin
      magnitude = {{(W-IMM_W){1'b0}}, imm};
    end
  end
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc #(
  parameter int W        = 32,
  parameter int PC_AHEAD = 8,
  parameter int LANE_W   = 2
) (
  input  logic [W-1:0]      base_val,
  input  logic [W-1:0]      inst_addr,
  input  logic              pc_rel,
  input  ea_pkg::idx_mode_e mode,
  input  logic [W-1:0]      magnitude,
  input  logic              neg,
  input  logic              word,
  output logic [W-1:0]      ea,
  output logic [W-1:0]      wb_val,
  output logic              wb_req,
  output logic              fault
);
  logic [W-1:0] eff_base;
  logic [W-1:0] sum;

  always_comb begin
    eff_base = pc_rel ? (inst_addr + W'(PC_AHEAD)) : base_val;
    sum      = neg ? (eff_base - magnitude) : (eff_base + magnitude);
    wb_val   = sum;
    if (!pc_rel && mode == ea_pkg::IDX_POST) begin
      ea = base_val;
    end else begin
      ea = sum;
    end
    fault  = word && (ea[LANE_W-1:0] != '0);
    wb_req = !pc_rel && !fault &&
             (mode == ea_pkg::IDX_PRE_WB || mode == ea_pkg::IDX_POST);
  end
endmodule

// File: rtl/ea_load_fmt.sv
module ea_load_fmt #(
  parameter int W      = 32,
  parameter int LANE_W = 2
) (
  input  logic [W-1:0]      raw,
  input  logic [LANE_W-1:0] lane_addr,
  input  logic              big_endian,
  input  logic              word,
  output logic [W-1:0]      result
);
  localparam int LANES = W / 8;

  logic [7:0]        lane [LANES];
  logic [LANE_W-1:0] pick;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane[k] = raw[8*k +: 8];
  end

  always_comb begin
    pick = big_endian ? LANE_W'(LANES - 1 - int'(lane_addr)) : lane_addr;
    if (word) begin
      result = raw;
    end else begin
      result = {{(W-8){1'b0}}, lane[pick]};
    end
  end
endmodule

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int W        = 32,
  parameter int IMM_W    = 12,
  parameter int SH_W     = 5,
  parameter int PC_AHEAD = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [W-1:0]     base_val,
  input  logic [W-1:0]     inst_addr,
  input  logic             pc_rel,
  input  logic [1:0]       idx_mode,
  input  logic             off_is_reg,
  input  logic [IMM_W-1:0] off_imm,
  input  logic [W-1:0]     off_reg,
  input  logic             off_neg,
  input  logic             shift_dir,
  input  logic [SH_W-1:0]  shift_amt,
  input  logic             size_word,
  input  logic             big_endian,
  input  logic [W-1:0]     load_word,
  output logic             rsp_valid,
  output logic [W-1:0]     eff_addr,
  output logic [W-1:0]     wb_value,
  output logic             wb_en,
  output logic             align_fault,
  output logic [W-1:0]     load_result
);
  import ea_pkg::*;

  localparam int LANE_W = $clog2(W / 8);

  idx_mode_e    mode;
  logic [W-1:0] magnitude;
  logic [W-1:0] ea_d, wbv_d;
  logic         wbreq_d, fault_d;

  // registered state and its next values
  logic         vld_q, vld_d;
  logic [W-1:0] ea_q, ea_n, wbv_q, wbv_n;
  logic         wbe_q, wbe_n, flt_q, flt_n;
  logic         word_q, word_n, be_q, be_n;

  assign mode = idx_mode_e'(idx_mode);

  ea_offset_gen #(.W(W), .IMM_W(IMM_W), .SH_W(SH_W)) u_off (
    .reg_off   (off_reg),
    .imm       (off_imm),
    .use_reg   (off_is_reg && !pc_rel),
    .dir       (shift_dir_e'(shift_dir)),
    .amt       (shift_amt),
    .magnitude (magnitude)
  );

  ea_addr_calc #(.W(W), .PC_AHEAD(PC_AHEAD), .LANE_W(LANE_W)) u_calc (
    .base_val  (base_val),
    .inst_addr (inst_addr),
    .pc_rel    (pc_rel),
    .mode      (mode),
    .magnitude (magnitude),
    .neg       (off_neg),
    .word      (size_word),
    .ea        (ea_d),
    .wb_val    (wbv_d),
    .wb_req    (wbreq_d),
    .fault     (fault_d)
  );

  always_comb begin
    vld_d  = req_valid;
    wbe_n  = req_valid && wbreq_d;
    flt_n  = req_valid && fault_d;
    ea_n   = ea_q;
    wbv_n  = wbv_q;
    word_n = word_q;
    be_n   = be_q;
    if (req_valid) begin
      ea_n   = ea_d;
      wbv_n  = wbv_d;
      word_n = size_word;
      be_n   = big_endian;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      ea_q   <= '0;
      wbv_q  <= '0;
      wbe_q  <= 1'b0;
      flt_q  <= 1'b0;
      word_q <= 1'b0;
      be_q   <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      ea_q   <= ea_n;
      wbv_q  <= wbv_n;
      wbe_q  <= wbe_n;
      flt_q  <= flt_n;
      word_q <= word_n;
      be_q   <= be_n;
    end
  end

  ea_load_fmt #(.W(W), .LANE_W(LANE_W)) u_fmt (
    .raw        (load_word),
    .lane_addr  (ea_q[LANE_W-1:0]),
    .big_endian (be_q),
    .word       (word_q),
    .result     (load_result)
  );

  assign rsp_valid   = vld_q;
  assign eff_addr    = ea_q;
  assign wb_value    = wbv_q;
  assign wb_en       = wbe_q;
  assign align_fault = flt_q;

  assert_fault_blocks_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_en && align_fault));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!wb_en && !align_fault));

  assert_pre_no_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && idx_mode == 2'd0) |=> !wb_en);

  assert_post_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pc_rel && idx_mode == 2'd2) |=> (eff_addr == $past(base_val)));

  assert_prewb_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pc_rel && idx_mode == 2'd1) |=> (wb_value == eff_addr));

  assert_pcrel_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pc_rel) |=> !wb_en);

  assert_word_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && word_q) |-> (load_result == load_word));
endmodule

// File: tb/sim_ea_unit.sv
module sim_ea_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] base_val = '0, inst_addr = '0, off_reg = '0, load_word = '0;
  logic        pc_rel = 1'b0, off_is_reg = 1'b0, off_neg = 1'b0, shift_dir = 1'b0;
  logic        size_word = 1'b0, big_endian = 1'b0;
  logic [1:0]  idx_mode = '0;
  logic [11:0] off_imm = '0;
  logic [4:0]  shift_amt = '0;
  logic        rsp_valid, wb_en, align_fault;
  logic [31:0] eff_addr, wb_value, load_result;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ea_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_val(base_val),
    .inst_addr(inst_addr), .pc_rel(pc_rel), .idx_mode(idx_mode),
    .off_is_reg(off_is_reg), .off_imm(off_imm), .off_reg(off_reg),
    .off_neg(off_neg), .shift_dir(shift_dir), .shift_amt(shift_amt),
    .size_word(size_word), .big_endian(big_endian), .load_word(load_word),
    .rsp_valid(rsp_valid), .eff_addr(eff_addr), .wb_value(wb_value),
    .wb_en(wb_en), .align_fault(align_fault), .load_result(load_result)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] b, input logic [31:0] ia, input logic pr,
                       input logic [1:0] md, input logic isr, input logic [11:0] imm,
                       input logic [31:0] ro, input logic ng, input logic sd,
                       input logic [4:0] sa, input logic sw, input logic be,
                       input logic [31:0] lw);
    logic [31:0] off, eb, sum, ea, lr;
    logic        flt, wbe;
    int          k;
    // expected values from the requirements (R4, R5, R6)
    off = (isr && !pr) ? (sd ? (ro >> sa) : (ro << sa)) : {20'd0, imm};
    eb  = pr ? ia + 32'd8 : b;
    sum = ng ? eb - off : eb + off;
    ea  = (!pr && md == 2'd2) ? b : sum;                 // R1 R2 R3 R10
    flt = sw && (ea[1:0] != 2'b00);                       // R7
    wbe = !pr && !flt && (md == 2'd1 || md == 2'd2);
    k   = be ? 3 - int'(ea[1:0]) : int'(ea[1:0]);         // R8
    lr  = sw ? lw : {24'd0, lw[8*k +: 8]};

    @(negedge clk);
    req_valid = 1'b1; base_val = b; inst_addr = ia; pc_rel = pr; idx_mode = md;
    off_is_reg = isr; off_imm = imm; off_reg = ro; off_neg = ng; shift_dir = sd;
    shift_amt = sa; size_word = sw; big_endian = be;
    @(negedge clk);
    req_valid = 1'b0; base_val = ~b; off_reg = ~ro; load_word = lw;
    #1;
    chk("R9 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(pr ? "R6 eff_addr" : "R1/R2/R3 eff_addr", eff_addr, ea);
    chk("R4 wb_value", wb_value, sum);
    chk("R7 align_fault", {31'd0, align_fault}, {31'd0, flt});
    chk(pr ? "R6 wb_en" : "R2/R3 wb_en", {31'd0, wb_en}, {31'd0, wbe});
    chk("R8 load_result", load_result, lr);
  endtask

  initial begin
    logic [31:0] seed;
    logic [31:0] bases [4];
    logic [4:0]  amts [4];
    seed = 32'h1234_5678;
    bases[0] = 32'h1000_0000; bases[1] = 32'h0000_0003;
    bases[2] = 32'hFFFF_FFFE; bases[3] = 32'h8000_1001;
    amts[0] = 5'd0; amts[1] = 5'd1; amts[2] = 5'd4; amts[3] = 5'd31;
    #1;
    // reset state, R9
    chk("R9 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R9 reset eff_addr", eff_addr, 32'd0);
    chk("R9 reset wb_en", {31'd0, wb_en}, 32'd0);
    chk("R9 reset align_fault", {31'd0, align_fault}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R9 idle wb_value", wb_value, 32'd0);

    // near-exhaustive sweep over controls, R1..R10
    for (int bi = 0; bi < 4; bi++)
      for (int md = 0; md < 4; md++)
        for (int pr = 0; pr < 2; pr++)
          for (int isr = 0; isr < 2; isr++)
            for (int ng = 0; ng < 2; ng++)
              for (int sd = 0; sd < 2; sd++)
                for (int ai = 0; ai < 4; ai++)
                  for (int sw = 0; sw < 2; sw++)
                    for (int be = 0; be < 2; be++) begin
                      seed = seed * 32'd1664525 + 32'd1013904223;
                      apply(bases[bi], {seed[31:2], 2'b00} ^ 32'h0000_0100,
                            1'(pr), 2'(md), 1'(isr),
                            (ai == 3) ? 12'hFFF : seed[27:16],
                            {seed[15:0], seed[31:16]} & ((ai == 0) ? 32'hFFFF_FFFC : 32'hFFFF_FFFF),
                            1'(ng), 1'(sd), amts[ai], 1'(sw), 1'(be),
                            32'hA1B2_C3D4 ^ {seed[7:0], 24'd0});
                    end

    // R7: post-indexed word access faults on the base, writeback cancelled
    apply(32'h0000_1002, 32'd0, 1'b0, 2'd2, 1'b0, 12'd2, 32'd0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 32'h0);
    // R7: pre with writeback lands aligned after a misaligned base
    apply(32'h0000_1002, 32'd0, 1'b0, 2'd1, 1'b0, 12'd2, 32'd0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 32'h0);
    // R6: PC-relative with the largest immediate
    apply(32'h5555_5555, 32'h0000_1000, 1'b1, 2'd1, 1'b1, 12'd4095, 32'hFFFF_FFFF, 1'b1, 1'b0, 5'd3, 1'b0, 1'b1, 32'h0102_0304);
    // R8: every lane, both byte orders
    for (int ln = 0; ln < 4; ln++)
      for (int be = 0; be < 2; be++)
        apply(32'h2000_0000 + 32'(ln), 32'd0, 1'b0, 2'd0, 1'b0, 12'd0, 32'd0, 1'b0, 1'b0,
              5'd0, 1'b0, 1'(be), 32'h4433_2211);

    @(negedge clk);
    chk("R9 quiet after request", {30'd0, wb_en, align_fault}, 32'd0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule